// File: doc/BRIEF.md
# Sliding Window Idle Enforcer

This block sits between a memory user and a multi-banked dynamic memory whose refresh scheduler needs slots in which it can act. The user raises an access request in each timeslot in which it wants the memory. The enforcer grants the request, or it stalls it so that the slot stays free for refresh. Its guarantee is that, over any Y consecutive slots starting at any position, at least X slots are usable for refresh. The constraint slides over every start position, so the forced idle slots do not have to fall on fixed boundaries.

A slot counts as usable for refresh in two cases: no access was granted in it, or the refresh scheduler reports through the no-conflict input that the access did not touch the bank it wanted to refresh. A stall is forced only when granting would leave the window ending at the current slot with fewer than X usable slots. Bursts of up to Y−X back-to-back accesses therefore pass without interruption. Under adversarial traffic, X/Y of the bandwidth is given up.

The decision is combinational within the slot. The history of the previous Y−1 slots is held in a shift register. A parameter selects whether the usable slots are counted by a running up/down counter or by a population count over that history.

Top module: `slot_idle_enforcer`

## Requirements
- R1: After reset the history reads as all usable. The first Y−X consecutive requests with no_conflict_i low are granted, and request number Y−X+1 is stalled.
- R2: In every window of Y consecutive slots, counting slots before reset as usable, at least X slots are usable. A usable slot has acc_grant_o low or no_conflict_i high.
- R3: A request presented with no_conflict_i high is always granted.
- R4: A request with no_conflict_i low is granted exactly when at least X of the previous Y−1 slots were usable.
- R5: acc_grant_o is high only with a request. acc_stall_o is high exactly when a request is not granted. While rst_n is low no request is granted.
- R6: Under sustained requests with no_conflict_i low, grants come in runs of exactly Y−X separated by runs of exactly X stalls.
- R7: A no-conflict slot inside a burst counts as usable, so the burst continues past Y−X grants.
- R8: Slots without a request count as usable. After Y−1 such slots a full burst of Y−X grants is available again.
- R9: Parameters with X < 1 or X ≥ Y are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one timeslot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req_i | input | 1 | User wants an access in this slot |
| no_conflict_i | input | 1 | Refresh scheduler reports that this slot's access does not block its refresh |
| acc_grant_o | output | 1 | Access permitted in this slot |
| acc_stall_o | output | 1 | Request held back so that the slot stays free for refresh |

## Verification
The bench builds two instances from the same stimulus. One uses X=2, Y=8 with the running counter, so multi-slot stall runs and six-grant bursts appear. The other uses X=1, Y=3 with the population count, so the smallest history and the stall-every-third-slot regime are reached within a few slots. Together the two instances cover both generate variants of the history. They also reach the window boundary right after reset, the interplay of no-conflict slots with a full burst, and recovery after idle gaps.

// File: rtl/swie_pkg.sv
package swie_pkg;

   typedef enum logic {
      HIST_RUNNING  = 1'b0,
      HIST_POPCOUNT = 1'b1
   } hist_style_e;

   // bits needed to hold a value in 0..n
   function automatic int count_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/swie_history.sv
module swie_history
   import swie_pkg::*;
#(
   parameter int          HLEN  = 7,
   parameter hist_style_e STYLE = HIST_RUNNING,
   localparam int         CW    = count_width(HLEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          qual_i,
   output logic [CW-1:0] cnt_o
);

   logic [HLEN-1:0] hist_q;

   // shift history, newest slot in bit 0; reset to all usable
   generate
      if (HLEN == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '1;
            else        hist_q <= qual_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '1;
            else        hist_q <= {hist_q[HLEN-2:0], qual_i};
         end
      end
   endgenerate

   generate
      if (STYLE == HIST_RUNNING) begin : g_running
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= CW'(HLEN);
            else        cnt_q <= cnt_q + CW'(qual_i) - CW'(hist_q[HLEN-1]);
         end
         assign cnt_o = cnt_q;
      end else begin : g_popcount
         logic [CW-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < HLEN; i++) acc = acc + CW'(hist_q[i]);
         end
         assign cnt_o = acc;
      end
   endgenerate

endmodule

// File: rtl/swie_decide.sv
module swie_decide
   import swie_pkg::*;
#(
   parameter int  IDLE_MIN = 2,
   parameter int  HLEN     = 7,
   localparam int CW       = count_width(HLEN)
) (
   input  logic          run_i,
   input  logic          req_i,
   input  logic          nc_i,
   input  logic [CW-1:0] cnt_i,
   output logic          grant_o,
   output logic          stall_o,
   output logic          qual_o
);

   logic room;

   always_comb begin
      room    = (cnt_i >= CW'(IDLE_MIN));
      grant_o = run_i & req_i & (nc_i | room);
      stall_o = req_i & ~grant_o;
      qual_o  = ~grant_o | nc_i;
   end

endmodule

// File: rtl/slot_idle_enforcer.sv
module slot_idle_enforcer
   import swie_pkg::*;
#(
   parameter int          IDLE_MIN = 2,
   parameter int          WIN_LEN  = 8,
   parameter hist_style_e STYLE    = HIST_RUNNING
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_req_i,
   input  logic no_conflict_i,
   output logic acc_grant_o,
   output logic acc_stall_o
);

   localparam int HLEN = WIN_LEN - 1;
   localparam int CW   = count_width(HLEN);

   // R9: parameter legality
   generate
      if (IDLE_MIN < 1) begin : g_bad_min
         $error("slot_idle_enforcer: IDLE_MIN must be at least 1");
      end
      if (IDLE_MIN >= WIN_LEN) begin : g_bad_win
         $error("slot_idle_enforcer: IDLE_MIN must be below WIN_LEN");
      end
   endgenerate

   logic          qual;
   logic [CW-1:0] past_cnt;

   swie_history #(
      .HLEN  (HLEN),
      .STYLE (STYLE)
   ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .qual_i (qual),
      .cnt_o  (past_cnt)
   );

   swie_decide #(
      .IDLE_MIN (IDLE_MIN),
      .HLEN     (HLEN)
   ) u_dec (
      .run_i   (rst_n),
      .req_i   (acc_req_i),
      .nc_i    (no_conflict_i),
      .cnt_i   (past_cnt),
      .grant_o (acc_grant_o),
      .stall_o (acc_stall_o),
      .qual_o  (qual)
   );

endmodule

// File: rtl/slot_idle_enforcer_chk.sv
module slot_idle_enforcer_chk #(
   parameter int X = 2,
   parameter int Y = 8
) (
   input logic clk,
   input logic rst_n,
   input logic acc_req_i,
   input logic no_conflict_i,
   input logic acc_grant_o,
   input logic acc_stall_o
);

   logic [Y-2:0] seen_q;
   logic         cur_ok;

   assign cur_ok = ~acc_grant_o | no_conflict_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '1;
      else        seen_q <= {seen_q[Y-3:0], cur_ok};
   end

   p_window_quota_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({seen_q, cur_ok}) >= X);

   p_nc_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_i && no_conflict_i) |-> acc_grant_o);

   p_room_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_i && ($countones(seen_q) >= X)) |-> acc_grant_o);

   p_needed_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stall_o |-> ($countones(seen_q) < X));

   p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_grant_o |-> acc_req_i);

   p_req_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req_i |-> (acc_grant_o ^ acc_stall_o));

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req_i |-> !acc_stall_o);

endmodule

bind slot_idle_enforcer slot_idle_enforcer_chk #(
   .X (IDLE_MIN),
   .Y (WIN_LEN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acc_req_i     (acc_req_i),
   .no_conflict_i (no_conflict_i),
   .acc_grant_o   (acc_grant_o),
   .acc_stall_o   (acc_stall_o)
);

// File: tb/tb_slot_idle_enforcer.sv
module tb_slot_idle_enforcer;
   import swie_pkg::*;

   localparam int XA = 2, YA = 8;
   localparam int XB = 1, YB = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, nc = 1'b0;
   logic g_a, s_a, g_b, s_b;
   logic [15:0] ha, hb;
   int checks = 0, errs = 0;
   int run_a;

   always #10 clk = ~clk;

   slot_idle_enforcer #(.IDLE_MIN(XA), .WIN_LEN(YA), .STYLE(HIST_RUNNING)) dut (
      .clk(clk), .rst_n(rst_n), .acc_req_i(req), .no_conflict_i(nc),
      .acc_grant_o(g_a), .acc_stall_o(s_a));

   slot_idle_enforcer #(.IDLE_MIN(XB), .WIN_LEN(YB), .STYLE(HIST_POPCOUNT)) dut_b (
      .clk(clk), .rst_n(rst_n), .acc_req_i(req), .no_conflict_i(nc),
      .acc_grant_o(g_b), .acc_stall_o(s_b));

   function automatic logic model(input logic [15:0] h, input int x, input int y,
                                  input logic r, input logic n);
      int c = 0;
      for (int i = 0; i < y - 1; i++) c += int'(h[i]);
      return r && (n || c >= x);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic slot(input logic r, input logic n, input string tag);
      logic ea, eb;
      @(negedge clk);
      req = r; nc = n;
      #5;
      ea = model(ha, XA, YA, r, n);
      eb = model(hb, XB, YB, r, n);
      chk({tag, " grant A"}, int'(g_a), int'(ea));
      chk({tag, " stall A"}, int'(s_a), int'(r && !ea));
      chk({tag, " grant B"}, int'(g_b), int'(eb));
      chk({tag, " stall B"}, int'(s_b), int'(r && !eb));
      ha = {ha[14:0], !ea || n};
      hb = {hb[14:0], !eb || n};
      run_a = ea ? run_a + 1 : 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req = 1'b1; nc = 1'b1;
      repeat (2) @(negedge clk);
      #5;
      chk("R5 grant in reset A", int'(g_a), 0);
      chk("R5 grant in reset B", int'(g_b), 0);
      @(negedge clk);
      req = 1'b0; nc = 1'b0; rst_n = 1'b1;
      ha = '1; hb = '1; run_a = 0;
   endtask

   // R1: first Y-X requests pass, the next one stalls
   task automatic t_first_burst();
      t_reset();
      for (int k = 0; k < YA - XA; k++) slot(1'b1, 1'b0, "R1 burst");
      chk("R1 burst length A", run_a, YA - XA);
      slot(1'b1, 1'b0, "R1 first stall");
      chk("R1 stall after burst A", int'(s_a), 1);
   endtask

   // R6: steady pattern of Y-X grants and X stalls
   task automatic t_sustained();
      int grants = 0;
      t_reset();
      for (int k = 0; k < 5 * YA; k++) begin
         slot(1'b1, 1'b0, "R6 sustained");
         grants += int'(g_a);
      end
      chk("R6 grants over 5 windows A", grants, 5 * (YA - XA));
      chk("R2 R4 run length bounded A", int'(run_a <= YA - XA), 1);
   endtask

   // R3 and R7: no-conflict slots extend the burst
   task automatic t_noconflict();
      t_reset();
      for (int k = 0; k < YA - XA; k++) slot(1'b1, 1'b0, "R7 pre");
      for (int k = 0; k < 4; k++) slot(1'b1, 1'b1, "R3 nc grant");
      chk("R7 burst extended A", run_a, YA - XA + 4);
      for (int k = 0; k < 3; k++) slot(1'b1, 1'b0, "R7 post");
   endtask

   // R8: idle gaps restore the full burst
   task automatic t_gap();
      t_reset();
      for (int k = 0; k < 12; k++) slot(1'b1, 1'b0, "R8 fill");
      for (int k = 0; k < YA - 1; k++) slot(1'b0, 1'b0, "R8 idle");
      chk("R8 idle no stall A", int'(s_a), 0);
      for (int k = 0; k < YA - XA; k++) slot(1'b1, 1'b0, "R8 refill");
      chk("R8 full burst again A", run_a, YA - XA);
   endtask

   // R2 R4: mixed traffic from an LFSR
   task automatic t_mixed();
      logic [15:0] lf = 16'hACE1;
      t_reset();
      for (int k = 0; k < 300; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         slot(lf[0] | lf[3], lf[5] & lf[7] & lf[9], "R4 mixed");
      end
   endtask

   initial begin
      #(20 * 150000);
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      ha = '1; hb = '1; run_a = 0;
      t_first_burst();
      t_sustained();
      t_noconflict();
      t_gap();
      t_mixed();
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

endmodule